// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two word-aligned stack pointers, a main pointer and a process pointer, behind one architectural stack-pointer view. Only one pointer is active at a time. Handler mode always selects the main pointer. Thread mode selects the process pointer when a select input is set. A separate special-register port reads or writes either pointer by index, including the pointer that is currently hidden.

Push and pop requests are single-cycle pulses, and each moves one word. A push lowers the active pointer by four and stores the data at the lowered address. A pop reads at the current address and then raises the pointer by four. The stack therefore grows downward, and the pointer always names the last stored word. The memory request goes out one cycle after the pulse, from a small sequencer with four states. ST_IDLE issues nothing. ST_PUSH issues a write. ST_POP issues a read. ST_FAULT raises the error flag. The state register reloads every cycle from that cycle's request:
- a push alone moves to ST_PUSH;
- a pop alone moves to ST_POP;
- both at once move to ST_FAULT;
- no request, or a request dropped by a colliding special-register write, moves to ST_IDLE.

A multi-word push or pop is a series of single pulses.

Top module: `sp_bank_unit`

## Requirements
- R1: After reset the main pointer holds parameter MAIN_RST and the process pointer holds PROC_RST, each with bits 1:0 cleared. With handler_mode=0 and thread_psp_sel=0 the active pointer is the main pointer.
- R2: While handler_mode=1, sp_rd shows the main pointer whatever the value of thread_psp_sel.
- R3: While handler_mode=0, sp_rd shows the process pointer when thread_psp_sel=1 and the main pointer when it is 0.
- R4: sr_rdata shows the pointer chosen by sr_sel in the same cycle (0 = main, 1 = process). A write with sr_we=1 replaces that pointer from the next clock edge.
- R5: Bits 1:0 of both pointers always read as zero, and the value in bits 1:0 of a special-register write is discarded.
- R6: A push alone lowers the active pointer by 4. In the following cycle mem_req=1, mem_we=1, mem_addr equals the lowered pointer and mem_wdata equals push_data from the request cycle.
- R7: A pop alone raises the active pointer by 4. In the following cycle mem_req=1, mem_we=0 and mem_addr equals the pointer value before the pop.
- R8: A push and a pop in the same cycle leave both pointers unchanged. In the following cycle op_err=1 and mem_req=0. At all other times op_err=0.
- R9: A special-register write to the pointer that a push or pop targets in the same cycle wins. The push or pop is dropped and mem_req stays 0 in the following cycle. A write to the other pointer does not disturb the push or pop.
- R10: A push or pop never changes the inactive pointer.
- R11: Pointer arithmetic wraps modulo 2^32. A push from 0 yields 0xFFFFFFFC, and a pop from 0xFFFFFFFC yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| thread_psp_sel | input | 1 | In thread mode, 1 selects the process pointer |
| push_req | input | 1 | Single-cycle push pulse |
| pop_req | input | 1 | Single-cycle pop pulse |
| push_data | input | 32 | Word to store on a push |
| sp_rd | output | 32 | Active stack pointer |
| sr_sel | input | 1 | Special-register pointer index (0 main, 1 process) |
| sr_we | input | 1 | Special-register write enable |
| sr_wdata | input | 32 | Special-register write value |
| sr_rdata | output | 32 | Pointer chosen by sr_sel |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Data of a write access |
| op_err | output | 1 | Simultaneous push and pop was seen |

## Verification
A bank register updated under the wrong index shows up as a wrong value on sp_rd or sr_rdata. It appears in the very next cycle, on whichever view selects that bank, so the bench reads both views every cycle. A sequencer in the wrong state shows up one cycle after the request, as a missing or extra strobe, a wrong read/write direction, or a stray error flag. A stale address or data latch is caught on the first access that uses it, because every access is compared against a model pointer kept in the bench.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUSH  = 2'd1,
        ST_POP   = 2'd2,
        ST_FAULT = 2'd3
    } sp_state_e;

    localparam int unsigned NBANK     = 2;
    localparam logic        BANK_MAIN = 1'b0;
    localparam logic        BANK_PROC = 1'b1;
endpackage

// File: rtl/sp_bank_select.sv
module sp_bank_select
    import sp_bank_pkg::*;
(
    input  logic handler_mode,
    input  logic thread_psp_sel,
    output logic active_idx
);
    // handler code is pinned to the main bank; thread code may opt for process
    always_comb begin
        if (handler_mode) active_idx = BANK_MAIN;
        else              active_idx = thread_psp_sel ? BANK_PROC : BANK_MAIN;
    end
endmodule

// File: rtl/sp_bank_regs.sv
module sp_bank_regs
    import sp_bank_pkg::*;
#(
    parameter int unsigned     WIDTH      = 32,
    parameter int unsigned     ALIGN_BITS = 2,
    parameter logic [WIDTH-1:0] RST_MAIN  = '0,
    parameter logic [WIDTH-1:0] RST_PROC  = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_idx,
    input  logic [WIDTH-1:0]            wr_val,
    input  logic                        adj_en,
    input  logic                        adj_idx,
    input  logic [WIDTH-1:0]            adj_val,
    output logic [NBANK-1:0][WIDTH-1:0] bank_val
);
    localparam logic [WIDTH-1:0] ALIGN_MASK = ~((WIDTH'(1) << ALIGN_BITS) - WIDTH'(1));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [WIDTH-1:0] RST_V = (b == 0) ? RST_MAIN : RST_PROC;
        logic [WIDTH-1:0] word_q;

        // special-register write outranks arithmetic on the same bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               word_q <= RST_V & ALIGN_MASK;
            else if (wr_en && (wr_idx == 1'(b)))      word_q <= wr_val & ALIGN_MASK;
            else if (adj_en && (adj_idx == 1'(b)))    word_q <= adj_val & ALIGN_MASK;
        end

        assign bank_val[b] = word_q;
    end
endmodule

// File: rtl/sp_bank_seq.sv
module sp_bank_seq
    import sp_bank_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             collide,
    input  logic [WIDTH-1:0] sp_cur,
    input  logic [WIDTH-1:0] push_data,
    output logic             adj_en,
    output logic [WIDTH-1:0] adj_val,
    output logic             mem_req,
    output logic             mem_we,
    output logic [WIDTH-1:0] mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    output logic             op_err
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1) << ALIGN_BITS;

    sp_state_e        state_q, state_d;
    logic [WIDTH-1:0] addr_q, data_q, addr_d;
    logic [WIDTH-1:0] sp_dec, sp_inc;

    assign sp_dec = sp_cur - STEP;
    assign sp_inc = sp_cur + STEP;

    // next state comes from this cycle's request pulse
    always_comb begin
        state_d = ST_IDLE;
        unique case ({push_req, pop_req})
            2'b11:   state_d = ST_FAULT;
            2'b10:   state_d = collide ? ST_IDLE : ST_PUSH;
            2'b01:   state_d = collide ? ST_IDLE : ST_POP;
            default: state_d = ST_IDLE;
        endcase
    end

    assign adj_en  = (state_d == ST_PUSH) || (state_d == ST_POP);
    assign adj_val = push_req ? sp_dec : sp_inc;
    // full-descending: push uses the lowered pointer, pop the current one
    assign addr_d  = push_req ? sp_dec : sp_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (adj_en)              addr_q <= addr_d;
            if (state_d == ST_PUSH)  data_q <= push_data;
        end
    end

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        op_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PUSH:  begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_POP:   mem_req = 1'b1;
            ST_FAULT: op_err = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;
endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit
    import sp_bank_pkg::*;
#(
    parameter int unsigned      WIDTH      = 32,
    parameter int unsigned      ALIGN_BITS = 2,
    parameter logic [WIDTH-1:0] MAIN_RST   = 32'h2000_1003,
    parameter logic [WIDTH-1:0] PROC_RST   = 32'h2000_0802
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             handler_mode,
    input  logic             thread_psp_sel,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] sp_rd,
    input  logic             sr_sel,
    input  logic             sr_we,
    input  logic [WIDTH-1:0] sr_wdata,
    output logic [WIDTH-1:0] sr_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [WIDTH-1:0] mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    output logic             op_err
);
    logic                        active_idx;
    logic                        collide;
    logic                        adj_en;
    logic [WIDTH-1:0]            adj_val;
    logic [NBANK-1:0][WIDTH-1:0] bank_val;

    sp_bank_select u_select (
        .handler_mode   (handler_mode),
        .thread_psp_sel (thread_psp_sel),
        .active_idx     (active_idx)
    );

    sp_bank_regs #(
        .WIDTH      (WIDTH),
        .ALIGN_BITS (ALIGN_BITS),
        .RST_MAIN   (MAIN_RST),
        .RST_PROC   (PROC_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sr_we),
        .wr_idx   (sr_sel),
        .wr_val   (sr_wdata),
        .adj_en   (adj_en),
        .adj_idx  (active_idx),
        .adj_val  (adj_val),
        .bank_val (bank_val)
    );

    assign sp_rd    = bank_val[active_idx];
    assign sr_rdata = bank_val[sr_sel];
    assign collide  = sr_we && (sr_sel == active_idx);

    sp_bank_seq #(
        .WIDTH      (WIDTH),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .collide   (collide),
        .sp_cur    (sp_rd),
        .push_data (push_data),
        .adj_en    (adj_en),
        .adj_val   (adj_val),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .op_err    (op_err)
    );
endmodule

// File: rtl/sp_bank_unit_chk.sv
module sp_bank_unit_chk #(
    parameter int unsigned WIDTH      = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             handler_mode,
    input logic             thread_psp_sel,
    input logic             push_req,
    input logic             pop_req,
    input logic [WIDTH-1:0] push_data,
    input logic [WIDTH-1:0] sp_rd,
    input logic             sr_sel,
    input logic             sr_we,
    input logic [WIDTH-1:0] sr_wdata,
    input logic [WIDTH-1:0] sr_rdata,
    input logic             mem_req,
    input logic             mem_we,
    input logic [WIDTH-1:0] mem_addr,
    input logic [WIDTH-1:0] mem_wdata,
    input logic             op_err
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1) << ALIGN_BITS;

    logic chk_act, chk_hit;
    assign chk_act = handler_mode ? 1'b0 : thread_psp_sel;
    assign chk_hit = sr_we && (sr_sel == chk_act);

    assert_handler_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_mode && !sr_sel) |-> (sp_rd == sr_rdata));

    assert_thread_proc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!handler_mode && thread_psp_sel && sr_sel) |-> (sp_rd == sr_rdata));

    assert_push_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !chk_hit) |=>
        (mem_req && mem_we && (mem_addr == $past(sp_rd) - STEP) && (mem_wdata == $past(push_data))));

    assert_pop_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !chk_hit) |=>
        (mem_req && !mem_we && (mem_addr == $past(sp_rd))));

    assert_conflict_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> (op_err && !mem_req));

    assert_err_only_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req) |=> !op_err);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_req ^ pop_req) && chk_hit) |=> !mem_req);
endmodule

bind sp_bank_unit sp_bank_unit_chk #(.WIDTH(WIDTH), .ALIGN_BITS(ALIGN_BITS)) chk_i (.*);

// File: tb/sp_bank_unit_tb_top.sv
`timescale 1ns/1ps
module sp_bank_unit_tb_top;
    localparam logic [31:0] MAIN_RST = 32'h2000_1003;
    localparam logic [31:0] PROC_RST = 32'h2000_0802;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        handler_mode, thread_psp_sel, push_req, pop_req;
    logic [31:0] push_data, sp_rd, sr_wdata, sr_rdata, mem_addr, mem_wdata;
    logic        sr_sel, sr_we, mem_req, mem_we, op_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_main, m_proc;
    logic        e_req, e_we, e_err;
    logic [31:0] e_addr, e_data;
    string       e_tag;

    always #2 clk = ~clk;

    sp_bank_unit #(.MAIN_RST(MAIN_RST), .PROC_RST(PROC_RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode), .thread_psp_sel(thread_psp_sel),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data), .sp_rd(sp_rd),
        .sr_sel(sr_sel), .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .op_err(op_err)
    );

    function automatic logic [31:0] align_w(input logic [31:0] v);
        return v & 32'hFFFF_FFFC;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_cycle(input logic h, input logic s, input logic pu, input logic po,
                             input logic [31:0] pd, input logic sw, input logic ss,
                             input logic [31:0] swd);
        logic        act;
        logic [31:0] av;
        handler_mode = h; thread_psp_sel = s; push_req = pu; pop_req = po;
        push_data = pd; sr_we = sw; sr_sel = ss; sr_wdata = swd;
        #1;
        act = h ? 1'b0 : s;
        av  = act ? m_proc : m_main;
        check(h ? "R2 active view" : "R3 active view", sp_rd, av);
        check((ss != act) ? "R10 hidden bank" : "R4 sr read", sr_rdata, ss ? m_proc : m_main);
        check(e_tag, {31'b0, mem_req}, {31'b0, e_req});
        if (e_req) begin
            check(e_tag, {31'b0, mem_we}, {31'b0, e_we});
            check(e_tag, mem_addr, e_addr);
            if (e_we) check(e_tag, mem_wdata, e_data);
        end
        check("R8 err flag", {31'b0, op_err}, {31'b0, e_err});
        // predict effect of this cycle
        e_err = pu && po;
        e_req = 1'b0;
        if (pu && po) e_tag = "R8 conflict";
        else if ((pu || po) && sw && (ss == act)) e_tag = "R9 write wins";
        else if (pu) begin
            e_req = 1'b1; e_we = 1'b1; e_addr = av - 32'd4; e_data = pd;
            e_tag = (av < 32'd4) ? "R11 push wrap" : "R6 push";
            if (act) m_proc = av - 32'd4; else m_main = av - 32'd4;
        end else if (po) begin
            e_req = 1'b1; e_we = 1'b0; e_addr = av;
            e_tag = (av == 32'hFFFF_FFFC) ? "R11 pop wrap" : "R7 pop";
            if (act) m_proc = av + 32'd4; else m_main = av + 32'd4;
        end else e_tag = "R4 idle";
        if (sw) begin
            if (ss) m_proc = align_w(swd); else m_main = align_w(swd);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        handler_mode = 0; thread_psp_sel = 0; push_req = 0; pop_req = 0;
        push_data = '0; sr_we = 0; sr_sel = 0; sr_wdata = '0;
        m_main = align_w(MAIN_RST); m_proc = align_w(PROC_RST);
        e_req = 0; e_we = 0; e_err = 0; e_addr = '0; e_data = '0; e_tag = "R1 reset";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 main after reset", sp_rd, 32'h2000_1000);
        sr_sel = 1'b1; #1;
        check("R1 proc after reset", sr_rdata, 32'h2000_0800);
        @(negedge clk);

        // R5: low bits of a write are discarded
        run_cycle(1'b0, 1'b1, 0, 0, '0, 1'b1, 1'b1, 32'h1234_5677);
        run_cycle(1'b0, 1'b1, 0, 0, '0, 1'b0, 1'b1, '0);
        check("R5 sr low bits", sr_rdata, 32'h1234_5674);
        check("R5 sp low bits", sp_rd, 32'h1234_5674);
        // R3 thread push on process bank, R2 handler ignores select
        run_cycle(1'b0, 1'b1, 1, 0, 32'hCAFE_0001, 1'b0, 1'b0, '0);
        run_cycle(1'b1, 1'b1, 1, 0, 32'hCAFE_0002, 1'b0, 1'b1, '0);
        run_cycle(1'b1, 1'b1, 0, 1, '0, 1'b0, 1'b0, '0);
        // R8 both requests
        run_cycle(1'b1, 1'b0, 1, 1, 32'h1, 1'b0, 1'b0, '0);
        // R9 colliding write, then write to the other bank
        run_cycle(1'b1, 1'b0, 1, 0, 32'h2, 1'b1, 1'b0, 32'h0000_4000);
        run_cycle(1'b1, 1'b0, 0, 1, '0, 1'b1, 1'b1, 32'h0000_8001);
        // R11 wrap around zero
        run_cycle(1'b1, 1'b0, 0, 0, '0, 1'b1, 1'b0, 32'h0000_0003);
        run_cycle(1'b1, 1'b0, 1, 0, 32'hBEEF, 1'b0, 1'b0, '0);
        run_cycle(1'b1, 1'b0, 0, 1, '0, 1'b0, 1'b0, '0);
        run_cycle(1'b1, 1'b0, 0, 0, '0, 1'b0, 1'b0, '0);
        check("R11 back to zero", sp_rd, 32'h0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            run_cycle(1'($urandom), 1'($urandom), (r < 4'd6), (r > 4'd10),
                      $urandom, ($urandom_range(0, 5) == 0), 1'($urandom), $urandom);
        end
        run_cycle(1'b0, 1'b0, 0, 0, '0, 1'b0, 1'b0, '0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule